// File: doc/BRIEF.md
# Flash block erase sequencer

This block steps one block of an on-chip flash array through erase and erase-verify. A start pulse arrives with a block-select vector, and that vector must select exactly one block. The sequencer then raises and lowers the array's software-write enable, erase-setup, erase and erase-verify lines in a fixed order. A programmable wait, given in clock cycles, follows each step. A watchdog-disable output covers the erase pulse.

After each erase pulse the block enters verify. It walks the selected block word by word. For each word it issues a dummy write of 0xFF, waits, and then reads one 16-bit word. A word that is not all ones ends the pass. A failed pass leads either to another erase pulse or, once a try limit is reached, to a failure report. A clean pass ends in a done report. To erase several blocks, the caller starts the sequencer once per block.

All block geometry is set by parameters: the number of blocks, the address width, the block size, the address step and the base of block 0. The waits are set by port values.

Top module: `fbe_seq`

## Requirements
- R1: A start taken while idle with zero or several bits set in `blk_sel` raises `sel_err` for exactly the next cycle. `busy` stays low and no array control line is driven.
- R2: An accepted start raises `swe` in the next cycle. Each later step follows the previous one by its wait plus one cycle. `esu` rises after `w_swe_set`. `ers` rises after `w_esu_set` and stays high for `w_ers_pulse`+1 cycles. `esu` falls after `w_ers_clr`. `ev` rises after `w_esu_clr`. `ers` is high only inside `esu`, and `ev` is never high together with `esu`.
- R3: `wdt_off` is high in exactly the cycles in which `ers` is high.
- R4: Block i spans `BASE0`+i*`BLK_BYTES` up to that value plus `BLK_BYTES`-`ASTEP`. After `ev` rises and `w_ev_set`+1 cycles pass, `fl_wr` pulses with `fl_wdata`=0xFF at the block base. `fl_rd` follows `w_dummy`+2 cycles after each `fl_wr`, at the same address. The address then steps by `ASTEP`, up to the block's last word.
- R5: A verify word passes only when `fl_rdata` is 16'hFFFF. The first failing word ends the pass with no further reads.
- R6: After a failed pass, `ev` falls. If the try count, which starts at 1 on each accepted start, is below `max_tries`, `esu` rises again `w_ev_clr`+1 cycles after `ev` falls, with `swe` held, and a new erase pulse follows.
- R7: A failed pass at a try count of at least `max_tries` drops `swe` `w_ev_clr`+1 cycles after `ev` falls. It then pulses `fail` `w_swe_clr`+1 cycles later.
- R8: A pass with every word all ones ends with the same `ev`/`swe` timing as R7, but pulses `done` instead of `fail`.
- R9: `busy` is high from the cycle after an accepted start through the `done` or `fail` cycle, and low after it. `done` and `fail` last one cycle each and are never high together.
- R10: A start while `busy` is ignored, whatever `blk_sel` holds. The running erase keeps its block's addresses and produces a single result.
- R11: There is no pre-write pass. `fl_wr` occurs only while `ev` is high, after an erase pulse, and always carries 0xFF.
- R12: Starts issued one after another on different blocks each run a full erase and verify on their own address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled while idle |
| blk_sel | input | NBLK | Block select, must be one-hot |
| max_tries | input | RW | Try limit N |
| w_swe_set | input | CW | Wait after software-write enable |
| w_esu_set | input | CW | Wait after erase setup |
| w_ers_pulse | input | CW | Erase pulse length |
| w_ers_clr | input | CW | Wait after erase drops |
| w_esu_clr | input | CW | Wait after erase setup drops |
| w_ev_set | input | CW | Wait after verify enable |
| w_dummy | input | CW | Wait after dummy write |
| w_ev_clr | input | CW | Wait after verify drops |
| w_swe_clr | input | CW | Wait after software-write drops |
| fl_rdata | input | 16 | Verify word from the array |
| swe | output | 1 | Software-write enable line |
| esu | output | 1 | Erase-setup line |
| ers | output | 1 | Erase line |
| ev | output | 1 | Erase-verify line |
| wdt_off | output | 1 | Watchdog disable |
| fl_wr | output | 1 | Dummy write strobe |
| fl_rd | output | 1 | Verify read strobe |
| fl_wdata | output | 8 | Dummy write data |
| fl_addr | output | AW | Verify address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Erase succeeded pulse |
| fail | output | 1 | Erase failed pulse |
| sel_err | output | 1 | Rejected select pulse |

## Verification
A new start request can arrive in the same cycle as the sequence's own steps. The case that matters most is a start landing during the verify walk, when addresses advance and read strobes fire. The bench provokes this by pulsing `start` with a different one-hot block in the middle of a retrying erase. It then judges the result at the ports: every dummy write and read must stay on the first block's address sequence, there must be exactly one `done`, and the erase pulse count must stay as expected.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_SWE, ST_ESU, ST_ERS, ST_ERS_OFF, ST_ESU_OFF,
      ST_EV_ON, ST_DWR, ST_DUM, ST_RD, ST_EV_OFF, ST_SWE_OFF, ST_FIN
   } fbe_state_e;

   localparam int VW = 16;
   localparam logic [7:0] DUMMY_BYTE = 8'hFF;
endpackage

// File: rtl/fbe_selchk.sv
module fbe_selchk #(
   parameter int NBLK      = 4,
   parameter int AW        = 8,
   parameter int BLK_BYTES = 16,
   parameter int ASTEP     = 2,
   parameter int BASE0     = 0
) (
   input  logic [NBLK-1:0] sel_i,
   output logic            ok_o,
   output logic [AW-1:0]   base_o,
   output logic [AW-1:0]   last_o
);
   localparam int SCW = $clog2(NBLK + 1);
   localparam logic [AW-1:0] LAST_OFF = AW'(BLK_BYTES - ASTEP);

   logic [NBLK-1:0][AW-1:0] base_tab;
   logic [SCW-1:0]          nset;
   logic [AW-1:0]           base_or;

   for (genvar gi = 0; gi < NBLK; gi++) begin : g_base
      assign base_tab[gi] = AW'(BASE0 + gi * BLK_BYTES);
   end

   always_comb begin
      nset    = '0;
      base_or = '0;
      for (int i = 0; i < NBLK; i++) begin
         nset = nset + SCW'(sel_i[i]);
         if (sel_i[i]) base_or = base_or | base_tab[i];
      end
   end

   assign ok_o   = (nset == SCW'(1));
   assign base_o = base_or;
   assign last_o = base_or + LAST_OFF;
endmodule

// File: rtl/fbe_timer.sv
module fbe_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (ld_i)           cnt_q <= ld_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);

   a_r2_tmr_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/fbe_addr.sv
module fbe_addr #(
   parameter int AW    = 8,
   parameter int ASTEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] last_i,
   input  logic          rewind_i,
   input  logic          step_i,
   output logic [AW-1:0] addr_o,
   output logic          at_last_o
);
   logic [AW-1:0] base_q, last_q, addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         last_q <= '0;
         addr_q <= '0;
      end else if (take_i) begin
         base_q <= base_i;
         last_q <= last_i;
         addr_q <= base_i;
      end else if (rewind_i) begin
         addr_q <= base_q;
      end else if (step_i) begin
         addr_q <= addr_q + AW'(ASTEP);
      end
   end

   assign addr_o    = addr_q;
   assign at_last_o = (addr_q == last_q);

   a_r4_no_step_past_last: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (addr_q != last_q));
   a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !take_i && !rewind_i) |=> (addr_q == $past(addr_q) + AW'(ASTEP)));
endmodule

// File: rtl/fbe_seq.sv
module fbe_seq
   import fbe_pkg::*;
#(
   parameter int NBLK      = 4,
   parameter int AW        = 8,
   parameter int BLK_BYTES = 16,
   parameter int ASTEP     = 2,
   parameter int BASE0     = 0,
   parameter int CW        = 8,
   parameter int RW        = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NBLK-1:0] blk_sel,
   input  logic [RW-1:0]   max_tries,
   input  logic [CW-1:0]   w_swe_set,
   input  logic [CW-1:0]   w_esu_set,
   input  logic [CW-1:0]   w_ers_pulse,
   input  logic [CW-1:0]   w_ers_clr,
   input  logic [CW-1:0]   w_esu_clr,
   input  logic [CW-1:0]   w_ev_set,
   input  logic [CW-1:0]   w_dummy,
   input  logic [CW-1:0]   w_ev_clr,
   input  logic [CW-1:0]   w_swe_clr,
   input  logic [15:0]     fl_rdata,
   output logic            swe,
   output logic            esu,
   output logic            ers,
   output logic            ev,
   output logic            wdt_off,
   output logic            fl_wr,
   output logic            fl_rd,
   output logic [7:0]      fl_wdata,
   output logic [AW-1:0]   fl_addr,
   output logic            busy,
   output logic            done,
   output logic            fail,
   output logic            sel_err
);
   initial begin
      assert (NBLK >= 1) else $error("NBLK must be at least 1");
      assert (ASTEP >= 1 && BLK_BYTES % ASTEP == 0) else $error("block size must be a multiple of the step");
      assert (BASE0 + NBLK * BLK_BYTES <= (1 << AW)) else $error("blocks exceed address space");
      assert (RW >= 1 && CW >= 1) else $error("counter widths must be positive");
   end

   fbe_state_e    st_q, st_n;
   logic          tz, ld, sel_ok, at_last, rd_bad;
   logic [CW-1:0] ld_val;
   logic [AW-1:0] sel_base, sel_last;
   logic [RW-1:0] tries_q;
   logic          bad_q, sel_err_q, wdt_q;
   logic          take, rewind, step;

   fbe_selchk #(.NBLK(NBLK), .AW(AW), .BLK_BYTES(BLK_BYTES), .ASTEP(ASTEP), .BASE0(BASE0))
      u_sel (.sel_i(blk_sel), .ok_o(sel_ok), .base_o(sel_base), .last_o(sel_last));

   fbe_timer #(.W(CW))
      u_tmr (.clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_val_i(ld_val), .zero_o(tz));

   fbe_addr #(.AW(AW), .ASTEP(ASTEP))
      u_addr (.clk(clk), .rst_n(rst_n), .take_i(take), .base_i(sel_base), .last_i(sel_last),
              .rewind_i(rewind), .step_i(step), .addr_o(fl_addr), .at_last_o(at_last));

   assign rd_bad = (fl_rdata != {VW{1'b1}});

   always_comb begin
      st_n = st_q;
      unique case (st_q)
         ST_IDLE:    if (start && sel_ok) st_n = ST_SWE;
         ST_SWE:     if (tz) st_n = ST_ESU;
         ST_ESU:     if (tz) st_n = ST_ERS;
         ST_ERS:     if (tz) st_n = ST_ERS_OFF;
         ST_ERS_OFF: if (tz) st_n = ST_ESU_OFF;
         ST_ESU_OFF: if (tz) st_n = ST_EV_ON;
         ST_EV_ON:   if (tz) st_n = ST_DWR;
         ST_DWR:     st_n = ST_DUM;
         ST_DUM:     if (tz) st_n = ST_RD;
         ST_RD:      st_n = (rd_bad || at_last) ? ST_EV_OFF : ST_DWR;
         ST_EV_OFF:  if (tz) st_n = (!bad_q || tries_q >= max_tries) ? ST_SWE_OFF : ST_ESU;
         ST_SWE_OFF: if (tz) st_n = ST_FIN;
         ST_FIN:     st_n = ST_IDLE;
         default:    st_n = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st_n)
         ST_SWE:     ld_val = w_swe_set;
         ST_ESU:     ld_val = w_esu_set;
         ST_ERS:     ld_val = w_ers_pulse;
         ST_ERS_OFF: ld_val = w_ers_clr;
         ST_ESU_OFF: ld_val = w_esu_clr;
         ST_EV_ON:   ld_val = w_ev_set;
         ST_DUM:     ld_val = w_dummy;
         ST_EV_OFF:  ld_val = w_ev_clr;
         ST_SWE_OFF: ld_val = w_swe_clr;
         default:    ld_val = '0;
      endcase
   end

   assign ld     = (st_n != st_q);
   assign take   = (st_q == ST_IDLE) && (st_n == ST_SWE);
   assign rewind = (st_q == ST_ESU_OFF) && (st_n == ST_EV_ON);
   assign step   = (st_q == ST_RD) && (st_n == ST_DWR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         tries_q   <= '0;
         bad_q     <= 1'b0;
         sel_err_q <= 1'b0;
         wdt_q     <= 1'b0;
      end else begin
         st_q      <= st_n;
         sel_err_q <= (st_q == ST_IDLE) && start && !sel_ok;
         wdt_q     <= (st_n == ST_ERS);
         if (take)
            tries_q <= RW'(1);
         else if (st_q == ST_EV_OFF && st_n == ST_ESU)
            tries_q <= tries_q + RW'(1);
         if (rewind)
            bad_q <= 1'b0;
         else if (st_q == ST_RD && rd_bad)
            bad_q <= 1'b1;
      end
   end

   assign swe      = !(st_q inside {ST_IDLE, ST_SWE_OFF, ST_FIN});
   assign esu      = st_q inside {ST_ESU, ST_ERS, ST_ERS_OFF};
   assign ers      = (st_q == ST_ERS);
   assign ev       = st_q inside {ST_EV_ON, ST_DWR, ST_DUM, ST_RD};
   assign fl_wr    = (st_q == ST_DWR);
   assign fl_rd    = (st_q == ST_RD);
   assign fl_wdata = DUMMY_BYTE;
   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_FIN) && !bad_q;
   assign fail     = (st_q == ST_FIN) && bad_q;
   assign sel_err  = sel_err_q;
   assign wdt_off  = wdt_q;

   a_r1_err_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |-> !busy);
   a_r2_ers_inside_esu: assert property (@(posedge clk) disable iff (!rst_n)
      ers |-> (esu && swe));
   a_r2_ev_excludes_esu: assert property (@(posedge clk) disable iff (!rst_n)
      ev |-> (!esu && swe));
   a_r3_wdt_tracks_ers: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_off == ers);
   a_r9_result_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
   a_r9_result_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |=> (!busy && !done && !fail));
   a_r11_wr_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr |-> ev);
   a_r6_tries_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      esu |-> (tries_q != '0));
endmodule

// File: tb/sim_fbe_seq.sv
`timescale 1ns/1ps
module sim_fbe_seq;
   localparam int NBLK = 4, AW = 8, BLK_BYTES = 16, ASTEP = 2, CW = 8, RW = 4;
   localparam int WX = 3, WY = 2, WZ = 5, WA = 1, WB = 2, WG = 1, WE = 2, WH = 1, WT = 3;

   typedef struct packed {
      logic [1:0] blk; logic [3:0] n; logic [3:0] need; logic [2:0] bad;
      logic ok; logic [3:0] pulses; logic [3:0] reads;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{2'd0, 4'd3, 4'd1, 3'd0, 1'b1, 4'd1, 4'd8},
      '{2'd2, 4'd3, 4'd2, 3'd3, 1'b1, 4'd2, 4'd8},
      '{2'd3, 4'd2, 4'd5, 3'd7, 1'b0, 4'd2, 4'd8},
      '{2'd1, 4'd4, 4'd4, 3'd0, 1'b1, 4'd4, 4'd8},
      '{2'd1, 4'd1, 4'd2, 3'd2, 1'b0, 4'd1, 4'd3}
   };

   logic clk = 0, rst_n = 0, start = 0;
   logic [NBLK-1:0] blk_sel = '0;
   logic [RW-1:0] max_tries = '0;
   logic [15:0] fl_rdata;
   logic swe, esu, ers, ev, wdt_off, fl_wr, fl_rd, busy, done, fail, sel_err;
   logic [7:0] fl_wdata;
   logic [AW-1:0] fl_addr;

   always #2 clk = ~clk;

   fbe_seq #(.NBLK(NBLK), .AW(AW), .BLK_BYTES(BLK_BYTES), .ASTEP(ASTEP), .BASE0(0), .CW(CW), .RW(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel), .max_tries(max_tries),
      .w_swe_set(CW'(WX)), .w_esu_set(CW'(WY)), .w_ers_pulse(CW'(WZ)), .w_ers_clr(CW'(WA)),
      .w_esu_clr(CW'(WB)), .w_ev_set(CW'(WG)), .w_dummy(CW'(WE)), .w_ev_clr(CW'(WH)),
      .w_swe_clr(CW'(WT)), .fl_rdata(fl_rdata),
      .swe(swe), .esu(esu), .ers(ers), .ev(ev), .wdt_off(wdt_off), .fl_wr(fl_wr), .fl_rd(fl_rd),
      .fl_wdata(fl_wdata), .fl_addr(fl_addr), .busy(busy), .done(done), .fail(fail), .sel_err(sel_err));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_total = 0, n_pass = 0;
   int cur_base = 0, need_r = 1, bad_r = 0;
   // monitor-owned
   int pulses, rd_pass, addr_bad, n_done, n_fail, exp_addr;
   int t_swe, t_esu, t_esu_l, t_ers_r, t_ers_f, t_esu_f, t_ev_r, t_ev_f, t_ev_fl, t_swe_f, t_wr, t_rd, t_end;
   int wdt_bad = 0, order_bad = 0, busy_bad = 0, sel_errs = 0, wr_bad = 0, prewr = 0;
   logic p_swe = 0, p_esu = 0, p_ers = 0, p_ev = 0, p_busy = 0, p_res = 0;

   always_comb begin
      int w;
      w = (int'(fl_addr) - cur_base) / ASTEP;
      if (pulses < need_r && w == bad_r) fl_rdata = 16'hFF7F;
      else fl_rdata = 16'hFFFF;
   end

   always @(negedge clk) begin
      if (busy && !p_busy) begin
         pulses = 0; rd_pass = 0; addr_bad = 0; n_done = 0; n_fail = 0; exp_addr = cur_base;
         t_swe = -1; t_esu = -1; t_esu_l = -1; t_ers_r = -1; t_ers_f = -1; t_esu_f = -1;
         t_ev_r = -1; t_ev_f = -1; t_ev_fl = -1; t_swe_f = -1; t_wr = -1; t_rd = -1; t_end = -1;
      end
      if (swe && !p_swe && t_swe < 0) t_swe = cyc;
      if (esu && !p_esu) begin if (t_esu < 0) t_esu = cyc; t_esu_l = cyc; end
      if (ers && !p_ers) begin pulses++; if (t_ers_r < 0) t_ers_r = cyc; end
      if (!ers && p_ers && t_ers_f < 0) t_ers_f = cyc;
      if (!esu && p_esu && t_esu_f < 0) t_esu_f = cyc;
      if (ev && !p_ev) begin if (t_ev_r < 0) t_ev_r = cyc; exp_addr = cur_base; rd_pass = 0; end
      if (!ev && p_ev) begin if (t_ev_f < 0) t_ev_f = cyc; t_ev_fl = cyc; end
      if (!swe && p_swe) t_swe_f = cyc;
      if (fl_wr) begin
         if (t_wr < 0) t_wr = cyc;
         if (fl_wdata != 8'hFF || !ev || int'(fl_addr) != exp_addr) wr_bad++;
         if (pulses == 0) prewr++;
      end
      if (fl_rd) begin
         if (t_rd < 0) t_rd = cyc;
         if (int'(fl_addr) != exp_addr) addr_bad++;
         exp_addr += ASTEP; rd_pass++;
      end
      if (done) begin n_done++; t_end = cyc; end
      if (fail) begin n_fail++; t_end = cyc; end
      if (wdt_off != ers) wdt_bad++;
      if ((esu && !swe) || (ers && !esu) || (ev && (esu || !swe))) order_bad++;
      if (((done || fail) && !busy) || (p_res && busy) || (done && fail)) busy_bad++;
      if (sel_err) sel_errs++;
      p_swe = swe; p_esu = esu; p_ers = ers; p_ev = ev; p_busy = busy; p_res = done || fail;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_total++;
      if (act == exp) n_pass++;
      else $display("FAIL %s act=%0d exp=%0d", req, act, exp);
   endtask

   int t0;
   task automatic run_one(input int blk, input int n, input int need, input int bad, input int inject);
      cur_base = blk * BLK_BYTES; need_r = need; bad_r = bad; max_tries = RW'(n);
      @(negedge clk); #1;
      blk_sel = NBLK'(1 << blk); start = 1; t0 = cyc;
      @(negedge clk); #1;
      start = 0;
      for (int k = 0; k < 4000 && (n_done + n_fail) == 0; k++) begin
         if (inject > 0 && k == inject) begin blk_sel = 4'b1000; start = 1; end
         if (inject > 0 && k == inject + 1) start = 0;
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_total++;
      $display("FAIL R9 watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R9 reset state
      chk("R9 reset busy", int'(busy), 0);
      chk("R2 reset lines", int'({swe, esu, ers, ev, wdt_off}), 0);
      chk("R9 reset results", int'({done, fail, sel_err, fl_wr, fl_rd}), 0);

      // R1: zero and multi-bit select rejected
      foreach (VECS[i]) ; // keeps table reachable before loop
      begin
         logic [3:0] bad_sel [2];
         bad_sel[0] = 4'b0000; bad_sel[1] = 4'b0110;
         for (int j = 0; j < 2; j++) begin
            blk_sel = bad_sel[j]; start = 1;
            @(negedge clk); #1; start = 0;
            chk("R1 sel_err pulse", int'(sel_err), 1);
            chk("R1 busy stays low", int'(busy), 0);
            @(negedge clk); #1;
            chk("R1 sel_err one cycle", int'(sel_err), 0);
            repeat (4) @(negedge clk); #1;
            chk("R1 no control line", int'({swe, esu, ers, ev, busy}), 0);
         end
         chk("R1 error count", sel_errs, 2);
      end

      // Table walk: R4 R5 R6 R7 R8 R12
      for (int i = 0; i < 5; i++) begin
         run_one(int'(VECS[i].blk), int'(VECS[i].n), int'(VECS[i].need), int'(VECS[i].bad), 0);
         chk($sformatf("R8 R7 vec%0d done", i), n_done, int'(VECS[i].ok));
         chk($sformatf("R7 vec%0d fail", i), n_fail, int'(!VECS[i].ok));
         chk($sformatf("R6 vec%0d erase pulses", i), pulses, int'(VECS[i].pulses));
         chk($sformatf("R5 vec%0d reads last pass", i), rd_pass, int'(VECS[i].reads));
         chk($sformatf("R12 vec%0d address walk", i), addr_bad, 0);
      end

      // Directed: timing, retry, start while busy (R2 R4 R6 R8 R9 R10)
      run_one(0, 3, 2, 0, 20);
      chk("R9 busy after start", t_swe - t0, 1);
      chk("R2 esu after swe", t_esu - t_swe, WX + 1);
      chk("R2 ers after esu", t_ers_r - t_esu, WY + 1);
      chk("R2 ers width", t_ers_f - t_ers_r, WZ + 1);
      chk("R2 esu drop", t_esu_f - t_ers_f, WA + 1);
      chk("R2 ev rise", t_ev_r - t_esu_f, WB + 1);
      chk("R4 first dummy write", t_wr - t_ev_r, WG + 1);
      chk("R4 read after write", t_rd - t_wr, WE + 2);
      chk("R6 esu again after ev drop", t_esu_l - t_ev_f, WH + 1);
      chk("R8 swe drop after ev drop", t_swe_f - t_ev_fl, WH + 1);
      chk("R8 done after swe drop", t_end - t_swe_f, WT + 1);
      chk("R10 single done", n_done, 1);
      chk("R10 addresses of first block", addr_bad, 0);
      chk("R10 pulses unchanged", pulses, 2);
      chk("R9 busy low after result", int'(busy), 0);

      // Fail timing (R7)
      run_one(2, 1, 3, 1, 0);
      chk("R7 fail pulse", n_fail, 1);
      chk("R7 fail after swe drop", t_end - t_swe_f, WT + 1);
      chk("R7 swe drop after ev drop", t_swe_f - t_ev_fl, WH + 1);

      chk("R3 wdt_off tracks ers", wdt_bad, 0);
      chk("R2 line order", order_bad, 0);
      chk("R9 busy and pulse shape", busy_bad, 0);
      chk("R11 dummy writes in verify", wr_bad, 0);
      chk("R11 no pre-write", prewr, 0);
      chk("R10 no stray sel_err", sel_errs, 2);

      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end
endmodule